// File: doc/BRIEF.md
# Synthesizer Counter Programming Interface

This block is the configuration front end of an integer-N frequency synthesizer. It holds the values for the reference divider (R), the main divider (M), the swallow counter (A) and the prescaler bypass bit, and it gives them to the dividers. Software or a board strap chooses one of three ways to load them. A serial shift port can load a 20-bit staging register or an 8-bit enhancement register. A byte-wide bus can write fixed, split fields of the staging register. Direct pins can drive the counters with no stored state.

The staging (primary) register is copied into a committed (secondary) register when a hop strobe or a serial load strobe rises. This lets a new channel be prepared while the old one stays in force. A select input, one for each mode, chooses which of the two registers drives the counters. The enhancement register reaches its output only while an active-low enable input is held low. All inputs are asynchronous to the system clock. They pass through synchronizers, and every strobe and the serial clock act on their synchronized rising edges.

Top module: `synth_prog_if`

## Requirements
- R1: After reset is released, every output reads zero: parallel mode, secondary register selected, all registers cleared.
- R2: The mode comes from two inputs. bmode_i=1 gives direct mode. bmode_i=0 with smode_i=1 gives serial mode. bmode_i=0 with smode_i=0 gives parallel mode.
- R3: In serial mode with s_wr_i low and e_wr_i low, each rising edge of sclk_i shifts sdata_i into bit 0 of the 20-bit primary register, so data enters MSB first. The primary layout is M in [19:11], R in [10:5], A in [4:1] and the prescaler bypass in [0].
- R4: In serial mode with s_wr_i low and e_wr_i high, each rising edge of sclk_i shifts sdata_i into the 8-bit enhancement register, MSB first. The primary register is left unchanged.
- R5: A rising edge of sclk_i changes no register while s_wr_i is high or while the block is not in serial mode.
- R6: The primary register is copied to the secondary register on a rising edge of hop_wr_i in serial or parallel mode, and on a rising edge of s_wr_i in serial mode.
- R7: In parallel mode, a rising edge of m1_wr_i writes data_i[7] to the prescaler bypass and data_i[6:0] to M[6:0].
- R8: In parallel mode, a rising edge of m2_wr_i writes data_i[3:2] to R[5:4] and data_i[1:0] to M[8:7]. No other field changes.
- R9: In parallel mode, a rising edge of a_wr_i writes data_i[7:4] to R[3:0] and data_i[3:0] to A[3:0].
- R10: In parallel mode, a rising edge of e_wr_i writes data_i into the enhancement register. The m1, m2 and a strobes have no effect outside parallel mode.
- R11: In serial mode fsel_ser_i picks the source, and in parallel mode fsel_par_i picks it. In both cases 1 selects the primary register and 0 selects the secondary register. The select of the other mode is ignored.
- R12: enh_o shows the enhancement register while enh_n_i is low, and shows zero while enh_n_i is high.
- R13: In direct mode, r_cnt_o, m_cnt_o and a_cnt_o are the zero-extended dir_r_i, dir_m_i and dir_a_i, and presc_byp_o is dir_byp_i.
- R14: A change on any input shows at the outputs after exactly the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bmode_i | input | 1 | Direct mode select |
| smode_i | input | 1 | Serial (1) or parallel (0) mode when not in direct mode |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data, MSB first |
| s_wr_i | input | 1 | Serial load strobe; shifting is allowed while it is low |
| e_wr_i | input | 1 | Enhancement target select (serial) or write strobe (parallel) |
| m1_wr_i | input | 1 | Parallel write strobe, M low field and bypass bit |
| m2_wr_i | input | 1 | Parallel write strobe, R and M high fields |
| a_wr_i | input | 1 | Parallel write strobe, R low field and A |
| hop_wr_i | input | 1 | Primary-to-secondary copy strobe |
| data_i | input | 8 | Parallel data bus |
| fsel_ser_i | input | 1 | Source select in serial mode |
| fsel_par_i | input | 1 | Source select in parallel mode |
| enh_n_i | input | 1 | Enhancement output enable, active low |
| dir_r_i | input | 4 | Direct-mode R value |
| dir_m_i | input | 7 | Direct-mode M value |
| dir_a_i | input | 4 | Direct-mode A value |
| dir_byp_i | input | 1 | Direct-mode prescaler bypass |
| r_cnt_o | output | 6 | R counter value |
| m_cnt_o | output | 9 | M counter value |
| a_cnt_o | output | 4 | A counter value |
| presc_byp_o | output | 1 | Prescaler bypass |
| enh_o | output | 8 | Gated enhancement bits |

## Verification
A corrupted primary register stays hidden while the secondary register is selected. It shows at the counter outputs three edges after the select is flipped, or three edges after the next hop or load strobe. A wrong secondary register or enhancement register shows at once whenever it is selected or enabled. Because of this, the bench switches the source selects after every kind of load, and it compares all outputs against a delayed reference on every cycle. Any error in field placement, shift order, gating or latency is then seen within three cycles of the stimulus that exposes it.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int R_W    = 6;
  localparam int M_W    = 9;
  localparam int A_W    = 4;
  localparam int ENH_W  = 8;
  localparam int BUS_W  = 8;
  localparam int DR_W   = 4;
  localparam int DM_W   = 7;
  localparam int DA_W   = 4;
  localparam int SYNC_N = 2;

  localparam int PRIM_W = M_W + R_W + A_W + 1;
  localparam int A_LSB  = 1;
  localparam int R_LSB  = A_LSB + A_W;
  localparam int M_LSB  = R_LSB + R_W;
  // split parallel fields
  localparam int M_LO_W = BUS_W - 1;
  localparam int M_HI_W = M_W - M_LO_W;
  localparam int R_LO_W = BUS_W - A_W;
  localparam int R_HI_W = R_W - R_LO_W;

  // strobe bus bit positions
  localparam int STB_SCLK = 0;
  localparam int STB_SWR  = 1;
  localparam int STB_EWR  = 2;
  localparam int STB_M1   = 3;
  localparam int STB_M2   = 4;
  localparam int STB_A    = 5;
  localparam int STB_HOP  = 6;
  localparam int STB_N    = 7;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } mode_e;

  typedef struct packed {
    logic             bmode;
    logic             smode;
    logic             fsel_ser;
    logic             fsel_par;
    logic             enh_n;
    logic             dir_byp;
    logic [DR_W-1:0]  dir_r;
    logic [DM_W-1:0]  dir_m;
    logic [DA_W-1:0]  dir_a;
    logic [BUS_W-1:0] data;
    logic             sdata;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic mode_e decode_mode(input logic bmode, input logic smode);
    if (bmode) return MODE_DIR;
    return smode ? MODE_SER : MODE_PAR;
  endfunction
endpackage

// File: rtl/synth_sync_pipe.sv
module synth_sync_pipe #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] dly_o
);
  logic [W-1:0] stg [STAGES+1];

  for (genvar g = 0; g <= STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign lvl_o = stg[STAGES-1];
  assign dly_o = stg[STAGES];
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [BUS_W-1:0]  data_i,
  input  logic              sdata_i,
  input  logic              s_wr_lvl_i,
  input  logic              e_wr_lvl_i,
  input  logic [STB_N-1:0]  rise_i,
  output logic [PRIM_W-1:0] prim_o,
  output logic [PRIM_W-1:0] sec_o,
  output logic [ENH_W-1:0]  enh_o
);
  logic [PRIM_W-1:0] prim_q, prim_d, sec_q;
  logic [ENH_W-1:0]  enh_q, enh_d;
  logic ser, par, shift_ok, prim_shift, enh_shift, enh_wr, copy;

  assign ser        = (mode_i == MODE_SER);
  assign par        = (mode_i == MODE_PAR);
  assign shift_ok   = ser && !s_wr_lvl_i && rise_i[STB_SCLK];
  assign prim_shift = shift_ok && !e_wr_lvl_i;
  assign enh_shift  = shift_ok && e_wr_lvl_i;
  assign enh_wr     = par && rise_i[STB_EWR];
  assign copy       = (ser && rise_i[STB_SWR]) || (!(mode_i == MODE_DIR) && rise_i[STB_HOP]);

  always_comb begin
    prim_d = prim_q;
    if (prim_shift) prim_d = {prim_q[PRIM_W-2:0], sdata_i};
    if (par && rise_i[STB_M1]) begin
      prim_d[0]                 = data_i[BUS_W-1];
      prim_d[M_LSB +: M_LO_W]   = data_i[M_LO_W-1:0];
    end
    if (par && rise_i[STB_M2]) begin
      prim_d[R_LSB+R_LO_W +: R_HI_W] = data_i[M_HI_W +: R_HI_W];
      prim_d[M_LSB+M_LO_W +: M_HI_W] = data_i[M_HI_W-1:0];
    end
    if (par && rise_i[STB_A]) begin
      prim_d[R_LSB +: R_LO_W] = data_i[A_W +: R_LO_W];
      prim_d[A_LSB +: A_W]    = data_i[A_W-1:0];
    end
  end

  always_comb begin
    enh_d = enh_q;
    if (enh_shift)   enh_d = {enh_q[ENH_W-2:0], sdata_i};
    else if (enh_wr) enh_d = data_i[ENH_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q <= '0;
      sec_q  <= '0;
      enh_q  <= '0;
    end else begin
      prim_q <= prim_d;
      enh_q  <= enh_d;
      if (copy) sec_q <= prim_q;
    end
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;
  assign enh_o  = enh_q;

  // R6
  copy_takes_prim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy |=> sec_q == $past(prim_q));
  // R6
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy |=> $stable(sec_q));
  // R5
  prim_direct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIR) |=> $stable(prim_q));
  // R4
  enh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enh_shift && !enh_wr) |=> $stable(enh_q));
endmodule

// File: rtl/synth_cnt_sel.sv
module synth_cnt_sel
  import synth_prog_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [PRIM_W-1:0] prim_i,
  input  logic [PRIM_W-1:0] sec_i,
  input  logic [ENH_W-1:0]  enh_i,
  output logic [R_W-1:0]    r_o,
  output logic [M_W-1:0]    m_o,
  output logic [A_W-1:0]    a_o,
  output logic              byp_o,
  output logic [ENH_W-1:0]  enh_o
);
  mode_e             mode;
  logic              use_prim;
  logic [PRIM_W-1:0] src;

  assign mode     = decode_mode(cfg_i.bmode, cfg_i.smode);
  assign use_prim = (mode == MODE_SER) ? cfg_i.fsel_ser : cfg_i.fsel_par;
  assign src      = use_prim ? prim_i : sec_i;

  always_comb begin
    r_o = '0;
    m_o = '0;
    a_o = '0;
    if (mode == MODE_DIR) begin
      r_o[DR_W-1:0] = cfg_i.dir_r;
      m_o[DM_W-1:0] = cfg_i.dir_m;
      a_o[DA_W-1:0] = cfg_i.dir_a;
      byp_o         = cfg_i.dir_byp;
    end else begin
      r_o   = src[R_LSB +: R_W];
      m_o   = src[M_LSB +: M_W];
      a_o   = src[A_LSB +: A_W];
      byp_o = src[0];
    end
  end

  assign enh_o = cfg_i.enh_n ? '0 : enh_i;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bmode_i,
  input  logic             smode_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             s_wr_i,
  input  logic             e_wr_i,
  input  logic             m1_wr_i,
  input  logic             m2_wr_i,
  input  logic             a_wr_i,
  input  logic             hop_wr_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic             fsel_ser_i,
  input  logic             fsel_par_i,
  input  logic             enh_n_i,
  input  logic [DR_W-1:0]  dir_r_i,
  input  logic [DM_W-1:0]  dir_m_i,
  input  logic [DA_W-1:0]  dir_a_i,
  input  logic             dir_byp_i,
  output logic [R_W-1:0]   r_cnt_o,
  output logic [M_W-1:0]   m_cnt_o,
  output logic [A_W-1:0]   a_cnt_o,
  output logic             presc_byp_o,
  output logic [ENH_W-1:0] enh_o
);
  cfg_t              cfg_in, cfg_lvl, cfg_dly;
  logic [CFG_W-1:0]  cfg_lvl_raw, cfg_dly_raw;
  logic [STB_N-1:0]  stb_in, stb_lvl, stb_dly, stb_rise;
  logic [PRIM_W-1:0] prim, sec;
  logic [ENH_W-1:0]  enh;

  assign cfg_in = '{bmode: bmode_i, smode: smode_i, fsel_ser: fsel_ser_i,
                    fsel_par: fsel_par_i, enh_n: enh_n_i, dir_byp: dir_byp_i,
                    dir_r: dir_r_i, dir_m: dir_m_i, dir_a: dir_a_i,
                    data: data_i, sdata: sdata_i};

  assign stb_in = {hop_wr_i, a_wr_i, m2_wr_i, m1_wr_i, e_wr_i, s_wr_i, sclk_i};

  // config takes the delayed tap so it lines up with strobe-driven register updates
  synth_sync_pipe #(.W(CFG_W), .STAGES(SYNC_N)) u_cfg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cfg_in),
    .lvl_o(cfg_lvl_raw), .dly_o(cfg_dly_raw)
  );
  assign cfg_lvl = cfg_t'(cfg_lvl_raw);
  assign cfg_dly = cfg_t'(cfg_dly_raw);

  synth_sync_pipe #(.W(STB_N), .STAGES(SYNC_N)) u_stb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stb_in),
    .lvl_o(stb_lvl), .dly_o(stb_dly)
  );
  assign stb_rise = stb_lvl & ~stb_dly;

  synth_prog_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (decode_mode(cfg_lvl.bmode, cfg_lvl.smode)),
    .data_i    (cfg_lvl.data),
    .sdata_i   (cfg_lvl.sdata),
    .s_wr_lvl_i(stb_lvl[STB_SWR]),
    .e_wr_lvl_i(stb_lvl[STB_EWR]),
    .rise_i    (stb_rise),
    .prim_o    (prim),
    .sec_o     (sec),
    .enh_o     (enh)
  );

  synth_cnt_sel u_sel (
    .cfg_i (cfg_dly),
    .prim_i(prim),
    .sec_i (sec),
    .enh_i (enh),
    .r_o   (r_cnt_o),
    .m_o   (m_cnt_o),
    .a_o   (a_cnt_o),
    .byp_o (presc_byp_o),
    .enh_o (enh_o)
  );

  // R14
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_rise[STB_SCLK] |=> !stb_rise[STB_SCLK]);
  // R12
  enh_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dly.enh_n |-> enh_o == '0);
  // R13
  direct_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dly.bmode |-> a_cnt_o == $past(cfg_lvl.dir_a));
  // R13
  direct_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dly.bmode |-> m_cnt_o == M_W'($past(cfg_lvl.dir_m)));
endmodule

// File: tb/synth_prog_if_tb.sv
`timescale 1ns/1ps
module synth_prog_if_tb;
  localparam int I_M1 = 0, I_M2 = 1, I_A = 2, I_E = 3, I_HOP = 4, I_SWR = 5;

  logic clk = 0, rst_n = 0;
  logic bmode = 0, smode = 0, sclk = 0, sdata = 0, s_wr = 0, e_wr = 0;
  logic m1_wr = 0, m2_wr = 0, a_wr = 0, hop_wr = 0;
  logic [7:0] data = 0;
  logic fsel_ser = 0, fsel_par = 0, enh_n = 0, dir_byp = 0;
  logic [3:0] dir_r = 0, dir_a = 0;
  logic [6:0] dir_m = 0;
  logic [5:0] r_cnt; logic [8:0] m_cnt; logic [3:0] a_cnt; logic byp; logic [7:0] enh;

  logic [19:0] prim_m = 0, sec_m = 0;
  logic [7:0]  enh_m = 0;
  logic [27:0] hist [3];
  string cur_req = "R1";
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_prog_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bmode_i(bmode), .smode_i(smode),
    .sclk_i(sclk), .sdata_i(sdata), .s_wr_i(s_wr), .e_wr_i(e_wr),
    .m1_wr_i(m1_wr), .m2_wr_i(m2_wr), .a_wr_i(a_wr), .hop_wr_i(hop_wr),
    .data_i(data), .fsel_ser_i(fsel_ser), .fsel_par_i(fsel_par), .enh_n_i(enh_n),
    .dir_r_i(dir_r), .dir_m_i(dir_m), .dir_a_i(dir_a), .dir_byp_i(dir_byp),
    .r_cnt_o(r_cnt), .m_cnt_o(m_cnt), .a_cnt_o(a_cnt), .presc_byp_o(byp), .enh_o(enh)
  );

  function automatic logic [27:0] exp_vec();
    logic [5:0] r; logic [8:0] m; logic [3:0] a; logic b; logic [7:0] e; logic [19:0] s;
    if (bmode) begin
      r = {2'b0, dir_r}; m = {2'b0, dir_m}; a = dir_a; b = dir_byp;
    end else begin
      s = (smode ? fsel_ser : fsel_par) ? prim_m : sec_m;
      m = s[19:11]; r = s[10:5]; a = s[4:1]; b = s[0];
    end
    e = enh_n ? 8'h00 : enh_m;
    return {r, m, a, b, e};
  endfunction

  // reference delayed by the three-edge input latency (R14)
  always @(posedge clk) begin
    hist[2] <= hist[1];
    hist[1] <= hist[0];
    hist[0] <= exp_vec();
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({r_cnt, m_cnt, a_cnt, byp, enh} !== hist[2]) begin
        fails++;
        $display("FAIL %s cycle compare act=%h exp=%h", cur_req,
                 {r_cnt, m_cnt, a_cnt, byp, enh}, hist[2]);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input int idx, input logic [7:0] d);
    logic par, ser;
    data = d;
    cyc(3);
    par = !bmode && !smode;
    ser = !bmode && smode;
    case (idx)
      I_M1: begin m1_wr = 1; if (par) begin prim_m[0] = d[7]; prim_m[17:11] = d[6:0]; end end
      I_M2: begin m2_wr = 1; if (par) begin prim_m[10:9] = d[3:2]; prim_m[19:18] = d[1:0]; end end
      I_A:  begin a_wr = 1; if (par) begin prim_m[8:5] = d[7:4]; prim_m[4:1] = d[3:0]; end end
      I_E:  begin e_wr = 1; if (par) enh_m = d; end
      I_HOP: begin hop_wr = 1; if (!bmode) sec_m = prim_m; end
      default: begin s_wr = 1; if (ser) sec_m = prim_m; end
    endcase
    cyc(4);
    m1_wr = 0; m2_wr = 0; a_wr = 0; hop_wr = 0; s_wr = 0; e_wr = 0;
    cyc(4);
  endtask

  task automatic sbit(input logic b);
    sdata = b;
    cyc(3);
    sclk = 1;
    if (!bmode && smode && !s_wr) begin
      if (e_wr) enh_m = {enh_m[6:0], b};
      else      prim_m = {prim_m[18:0], b};
    end
    cyc(3);
    sclk = 0;
    cyc(3);
  endtask

  initial begin
    logic [19:0] word;
    cyc(3);
    rst_n = 1;
    cyc(5);
    // R1
    chk("R1", {r_cnt, m_cnt, a_cnt, byp, enh}, 0);

    // parallel loads
    cur_req = "R7"; fsel_par = 1; cyc(4);
    pulse(I_M1, 8'hD5);
    chk("R7", m_cnt, 9'h055); chk("R7", byp, 1);
    cur_req = "R8"; pulse(I_M2, 8'h0E);
    chk("R8", m_cnt, 9'h155); chk("R8", r_cnt, 6'h30);
    cur_req = "R9"; pulse(I_A, 8'h9C);
    chk("R9", r_cnt, 6'h39); chk("R9", a_cnt, 4'hC);
    cur_req = "R6"; fsel_par = 0; cyc(4);
    chk("R6", r_cnt, 0);
    pulse(I_HOP, 8'h00);
    chk("R6", r_cnt, 6'h39); chk("R6", m_cnt, 9'h155);
    cur_req = "R10"; pulse(I_E, 8'h3C);
    chk("R10", enh, 8'h3C);
    cur_req = "R12"; enh_n = 1; cyc(4);
    chk("R12", enh, 0);
    enh_n = 0; cyc(4);
    chk("R12", enh, 8'h3C);

    // serial loads
    cur_req = "R3"; smode = 1; fsel_ser = 1; fsel_par = 0; cyc(4);
    word = 20'hA6C93;
    for (int i = 19; i >= 0; i--) sbit(word[i]);
    chk("R3", m_cnt, {23'd0, word[19:11]}); chk("R3", r_cnt, word[10:5]);
    chk("R3", a_cnt, word[4:1]); chk("R3", byp, word[0]);
    cur_req = "R5"; s_wr = 1; sec_m = prim_m; cyc(4);
    sbit(1'b0);
    s_wr = 0; cyc(4);
    chk("R5", a_cnt, word[4:1]); chk("R5", byp, word[0]);
    cur_req = "R6"; fsel_ser = 0; cyc(4);
    chk("R6", m_cnt, {23'd0, word[19:11]});
    cur_req = "R10"; fsel_ser = 1; pulse(I_M1, 8'hFF);
    chk("R10", m_cnt, {23'd0, word[19:11]});
    cur_req = "R4"; e_wr = 1; cyc(4);
    for (int i = 7; i >= 0; i--) sbit(logic'((8'h5A >> i) & 1));
    e_wr = 0; cyc(4);
    chk("R4", enh, 8'h5A); chk("R4", r_cnt, word[10:5]);

    // direct mode
    cur_req = "R13"; bmode = 1; dir_r = 4'h7; dir_m = 7'h2B; dir_a = 4'h3; dir_byp = 1; cyc(4);
    chk("R13", r_cnt, 6'h07); chk("R13", m_cnt, 9'h02B); chk("R13", a_cnt, 4'h3);
    cur_req = "R14"; dir_a = 4'hE;
    cyc(2); chk("R14", a_cnt, 4'h3);
    cyc(1); chk("R14", a_cnt, 4'hE);
    cur_req = "R5"; sbit(1'b1); pulse(I_HOP, 8'h00);
    cur_req = "R2"; bmode = 0; cyc(4);
    chk("R2", m_cnt, {23'd0, word[19:11]}); chk("R5", byp, word[0]);

    // per-mode source select
    cur_req = "R11"; smode = 0; fsel_par = 1; fsel_ser = 0; cyc(4);
    chk("R11", r_cnt, word[10:5]);
    fsel_par = 0; fsel_ser = 1; cyc(4);
    chk("R11", r_cnt, sec_m[10:5]);
    cur_req = "R2"; smode = 1; cyc(4);
    chk("R2", r_cnt, word[10:5]);
    cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog %s expired", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule